// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Table

Each node on a split-transaction snooping bus holds one copy of this table. The table follows every request that is still in flight on the bus. It learns about new requests by watching the address phase. That phase gives the tag, the block address, the issuing node and the command. It learns that a request has ended by watching the data phase, which returns only the tag. Because every node sees the same bus traffic, all copies of the table stay the same without any exchange between nodes.

Before a local requester drives an address request, it asks the table about it. The table answers with three things: whether the block is already in flight, whether a tag is free (a NACK if not, so the requester tries again later), and the lowest-numbered free tag to use. When a response retires a tag, the table reports the retired tag, node and command one cycle later. This tells the local node whom the response belongs to. Responses may come back in any order. Each table slot is a two-state machine. The state `ENT_FREE` moves to `ENT_BUSY` on an address-phase observation of its tag (transition *claim*). The state `ENT_BUSY` moves back to `ENT_FREE` on a data-phase response with its tag (transition *release*). It stays in `ENT_BUSY` and loads new contents when a claim and a release for its tag land in the same cycle (transition *reload*).

Top module: `split_req_table`

## Requirements
- R1: After reset, every slot is free. `ask_tag` is 0, `ask_conflict`, `ask_nack`, `ask_grant`, `done_valid` and `err_orphan` are all 0.
- R2: When `obs_valid` is high with tag T, slot T is occupied from the next cycle on, and T is no longer offered.
- R3: `ask_tag` is the lowest index whose slot is free and is not being claimed on `obs_*` in the same cycle. It is 0 when there is no such slot.
- R4: With `ask_valid` high, `ask_conflict` is 1 when `ask_addr` matches an occupied slot's address in every bit above the low `OFFS_W` offset bits. The offset bits are ignored.
- R5: With `ask_valid` high, `ask_conflict` is 1 when `ask_addr` is in the same block as an `obs_addr` being claimed in that same cycle.
- R6: With `ask_valid` high, `ask_nack` is 1 exactly when no slot is free after counting the claim made in the same cycle.
- R7: A response on `rsp_valid`/`rsp_tag` to an occupied slot frees only that slot, whatever order the responses arrive in. In the next cycle `done_valid` is 1, and `done_tag`, `done_node` and `done_cmd` carry that slot's tag, issuing node and command.
- R8: A claim and a release in the same cycle both take effect. If they name the same tag, the slot stays occupied and holds the newly claimed block.
- R9: A response whose tag names a free slot changes no slot. In the next cycle `err_orphan` is 1 and `done_valid` is 0.
- R10: `ask_grant` is 1 exactly when `ask_valid` is high and neither `ask_conflict` nor `ask_nack` is set. With `ask_valid` low, `ask_conflict`, `ask_nack` and `ask_grant` are 0.
- R11: A block whose slot was released no longer conflicts, starting from the cycle after the response. It still conflicts in the cycle of the response itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | Address-phase request seen on the bus |
| obs_tag | input | TAG_W | Tag carried by the observed request |
| obs_addr | input | ADDR_W | Byte address of the observed request |
| obs_node | input | NODE_W | Node that issued the observed request |
| obs_cmd | input | CMD_W | Command of the observed request |
| rsp_valid | input | 1 | Data-phase response seen on the bus |
| rsp_tag | input | TAG_W | Tag carried by the response |
| ask_valid | input | 1 | Local requester asks before issuing |
| ask_addr | input | ADDR_W | Address the local requester wants |
| ask_tag | output | TAG_W | Lowest free tag to issue with |
| ask_conflict | output | 1 | Block already in flight; hold back |
| ask_nack | output | 1 | No tag free; retry later |
| ask_grant | output | 1 | Request may be issued now |
| done_valid | output | 1 | A slot was retired last cycle |
| done_tag | output | TAG_W | Tag of the retired slot |
| done_node | output | NODE_W | Issuing node of the retired slot |
| done_cmd | output | CMD_W | Command of the retired slot |
| err_orphan | output | 1 | Last cycle's response matched no occupied slot |

## Verification
The bench builds the table with eight tags, 16-bit addresses, 4 offset bits, 2-bit node and 2-bit command fields. With eight tags, the full-table NACK and the NACK caused by a same-cycle claim of the last free tag can be reached in a few cycles. With only 12 block bits and a narrow address range in the random phase, block matches across different offsets happen often, so the conflict logic is exercised heavily. The narrow tag field also makes responses to free tags (orphans) and same-tag reloads frequent.

// File: rtl/ort_pkg.sv
package ort_pkg;
    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_BUSY = 1'b1
    } ent_state_e;
endpackage

// File: rtl/ort_lowest.sv
module ort_lowest #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ort_entry.sv
module ort_entry
    import ort_pkg::*;
#(
    parameter int BLK_W  = 12,
    parameter int NODE_W = 2,
    parameter int CMD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic              release_i,
    input  logic [BLK_W-1:0]  in_blk,
    input  logic [NODE_W-1:0] in_node,
    input  logic [CMD_W-1:0]  in_cmd,
    output logic              busy,
    output logic [BLK_W-1:0]  blk,
    output logic [NODE_W-1:0] node,
    output logic [CMD_W-1:0]  cmd
);
    ent_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (claim) state_d = ENT_BUSY;
            ENT_BUSY: begin
                if (claim)          state_d = ENT_BUSY;
                else if (release_i) state_d = ENT_FREE;
            end
            default: state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk  <= '0;
            node <= '0;
            cmd  <= '0;
        end else if (claim) begin
            blk  <= in_blk;
            node <= in_node;
            cmd  <= in_cmd;
        end
    end

    assign busy = (state_q == ENT_BUSY);

    AST_ENT_CLAIM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> busy); // R2
    AST_ENT_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && release_i && !claim) |=> !busy); // R7
    AST_ENT_HOLD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |=> $stable(blk)); // R8
endmodule

// File: rtl/split_req_table.sv
module split_req_table #(
    parameter int NUM_TAGS = 8,
    parameter int ADDR_W   = 16,
    parameter int OFFS_W   = 4,
    parameter int NODE_W   = 2,
    parameter int CMD_W    = 2,
    localparam int TAG_W   = $clog2(NUM_TAGS),
    localparam int BLK_W   = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [TAG_W-1:0]  obs_tag,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [NODE_W-1:0] obs_node,
    input  logic [CMD_W-1:0]  obs_cmd,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              ask_valid,
    input  logic [ADDR_W-1:0] ask_addr,
    output logic [TAG_W-1:0]  ask_tag,
    output logic              ask_conflict,
    output logic              ask_nack,
    output logic              ask_grant,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag,
    output logic [NODE_W-1:0] done_node,
    output logic [CMD_W-1:0]  done_cmd,
    output logic              err_orphan
);
    logic [NUM_TAGS-1:0] busy;
    logic [NUM_TAGS-1:0] match;
    logic [NUM_TAGS-1:0] avail;
    logic [BLK_W-1:0]    slot_blk  [NUM_TAGS];
    logic [NODE_W-1:0]   slot_node [NUM_TAGS];
    logic [CMD_W-1:0]    slot_cmd  [NUM_TAGS];

    logic [BLK_W-1:0] obs_blk, ask_blk;
    logic             unused_offs;
    assign obs_blk     = obs_addr[ADDR_W-1:OFFS_W];
    assign ask_blk     = ask_addr[ADDR_W-1:OFFS_W];
    assign unused_offs = ^{obs_addr[OFFS_W-1:0], ask_addr[OFFS_W-1:0]};

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        logic claim_g, release_g;
        assign claim_g   = obs_valid && (obs_tag == TAG_W'(g));
        assign release_g = rsp_valid && (rsp_tag == TAG_W'(g));

        ort_entry #(.BLK_W(BLK_W), .NODE_W(NODE_W), .CMD_W(CMD_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (claim_g),
            .release_i (release_g),
            .in_blk    (obs_blk),
            .in_node   (obs_node),
            .in_cmd    (obs_cmd),
            .busy      (busy[g]),
            .blk       (slot_blk[g]),
            .node      (slot_node[g]),
            .cmd       (slot_cmd[g])
        );

        assign match[g] = busy[g] && (slot_blk[g] == ask_blk);
        assign avail[g] = !busy[g] && !claim_g;
    end

    logic any_avail;
    ort_lowest #(.N(NUM_TAGS)) u_low (
        .req (avail),
        .idx (ask_tag),
        .any (any_avail)
    );

    logic same_now;
    assign same_now = obs_valid && (obs_blk == ask_blk);

    always_comb begin
        ask_conflict = ask_valid && ((|match) || same_now);
        ask_nack     = ask_valid && !any_avail;
        ask_grant    = ask_valid && !ask_conflict && !ask_nack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_tag   <= '0;
            done_node  <= '0;
            done_cmd   <= '0;
            err_orphan <= 1'b0;
        end else begin
            done_valid <= rsp_valid && busy[rsp_tag];
            err_orphan <= rsp_valid && !busy[rsp_tag];
            if (rsp_valid) begin
                done_tag  <= rsp_tag;
                done_node <= slot_node[rsp_tag];
                done_cmd  <= slot_cmd[rsp_tag];
            end
        end
    end

    AST_OFFERED_TAG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ask_valid && !ask_nack) |-> !busy[ask_tag]); // R3
    AST_NACK_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ask_nack |-> ($countones(busy) >= NUM_TAGS - 1)); // R6
    AST_DONE_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(rsp_valid) && ($past(rsp_tag) == done_tag))); // R7
    AST_ORPHAN_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        err_orphan |-> ($past(rsp_valid) && !done_valid)); // R9
endmodule

// File: tb/tb_split_req_table.sv
module tb_split_req_table;
    localparam int NUM_TAGS = 8;
    localparam int ADDR_W   = 16;
    localparam int OFFS_W   = 4;
    localparam int NODE_W   = 2;
    localparam int CMD_W    = 2;
    localparam int TAG_W    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              obs_valid = 1'b0;
    logic [TAG_W-1:0]  obs_tag = '0;
    logic [ADDR_W-1:0] obs_addr = '0;
    logic [NODE_W-1:0] obs_node = '0;
    logic [CMD_W-1:0]  obs_cmd = '0;
    logic              rsp_valid = 1'b0;
    logic [TAG_W-1:0]  rsp_tag = '0;
    logic              ask_valid = 1'b0;
    logic [ADDR_W-1:0] ask_addr = '0;
    logic [TAG_W-1:0]  ask_tag;
    logic              ask_conflict, ask_nack, ask_grant;
    logic              done_valid;
    logic [TAG_W-1:0]  done_tag;
    logic [NODE_W-1:0] done_node;
    logic [CMD_W-1:0]  done_cmd;
    logic              err_orphan;

    split_req_table #(.NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W),
                      .NODE_W(NODE_W), .CMD_W(CMD_W)) dut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit m_busy [NUM_TAGS];
    int m_blk  [NUM_TAGS];
    int m_node [NUM_TAGS];
    int m_cmd  [NUM_TAGS];
    bit e_done = 0, e_err = 0;
    int e_dtag = 0, e_dnode = 0, e_dcmd = 0;

    int  s_tag;
    bit  s_conf, s_nack, s_grant, s_done, s_err;
    int  s_dtag;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int blk_of(input int a);
        return a >> OFFS_W;
    endfunction

    task automatic cyc(input bit av, input int at, input int aa, input int an, input int ac,
                       input bit dv, input int dt, input bit qv, input int qa);
        int  x_tag;
        bit  x_conf, x_nack, x_any;
        obs_valid = av; obs_tag = TAG_W'(at); obs_addr = ADDR_W'(aa);
        obs_node = NODE_W'(an); obs_cmd = CMD_W'(ac);
        rsp_valid = dv; rsp_tag = TAG_W'(dt);
        ask_valid = qv; ask_addr = ADDR_W'(qa);
        #1;
        x_tag = 0; x_any = 0; x_conf = 0;
        for (int i = NUM_TAGS - 1; i >= 0; i--)
            if (!m_busy[i] && !(av && at == i)) begin x_tag = i; x_any = 1; end
        for (int i = 0; i < NUM_TAGS; i++)
            if (m_busy[i] && m_blk[i] == blk_of(qa)) x_conf = 1;
        if (av && blk_of(aa) == blk_of(qa)) x_conf = 1;
        x_conf = qv && x_conf;
        x_nack = qv && !x_any;
        s_tag = int'(ask_tag); s_conf = ask_conflict; s_nack = ask_nack; s_grant = ask_grant;
        s_done = done_valid; s_err = err_orphan; s_dtag = int'(done_tag);
        check(s_tag == x_tag, "R3 ask_tag", s_tag, x_tag);
        check(s_conf == x_conf, "R4 R5 ask_conflict", s_conf, x_conf);
        check(s_nack == x_nack, "R6 ask_nack", s_nack, x_nack);
        check(s_grant == (qv && !x_conf && !x_nack), "R10 ask_grant", s_grant, qv && !x_conf && !x_nack);
        check(s_done == e_done, "R7 done_valid", s_done, e_done);
        if (e_done) begin
            check(s_dtag == e_dtag, "R7 done_tag", s_dtag, e_dtag);
            check(int'(done_node) == e_dnode, "R7 done_node", int'(done_node), e_dnode);
            check(int'(done_cmd) == e_dcmd, "R7 done_cmd", int'(done_cmd), e_dcmd);
        end
        check(s_err == e_err, "R9 err_orphan", s_err, e_err);
        @(posedge clk);
        e_done = 0; e_err = 0;
        if (dv) begin
            if (m_busy[dt]) begin
                e_done = 1; e_dtag = dt; e_dnode = m_node[dt]; e_dcmd = m_cmd[dt];
                m_busy[dt] = 0;
            end else e_err = 1;
        end
        if (av) begin
            m_busy[at] = 1; m_blk[at] = blk_of(aa); m_node[at] = an; m_cmd[at] = ac;
        end
        @(negedge clk);
    endtask

    task automatic idle(input bit qv, input int qa);
        cyc(0, 0, 0, 0, 0, 0, 0, qv, qa);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_TAGS; i++) m_busy[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ask_tag == 0 && !ask_conflict && !ask_nack && !ask_grant, "R1 ask outputs", int'(ask_tag), 0);
        check(!done_valid && !err_orphan, "R1 done/err", int'(done_valid) + int'(err_orphan), 0);
        @(negedge clk);

        // same-cycle claim of block 0x123 while asking about it
        cyc(1, 0, 'h1230, 1, 2, 0, 0, 1, 'h1235);
        check(s_conf == 1, "R5 same-cycle claim", s_conf, 1);
        check(s_tag == 1, "R3 skip claimed tag", s_tag, 1);
        idle(1, 'h123F);
        check(s_conf == 1, "R4 offset ignored", s_conf, 1);
        check(s_tag == 1, "R2 tag0 occupied", s_tag, 1);
        idle(1, 'h1240);
        check(s_grant == 1, "R10 grant other block", s_grant, 1);

        for (int t = 1; t < NUM_TAGS - 1; t++) cyc(1, t, 'h2000 + t * 16, t % 4, t % 4, 0, 0, 0, 0);
        cyc(1, 7, 'h3000, 3, 1, 0, 0, 1, 'h5000);
        check(s_nack == 1, "R6 last tag claimed same cycle", s_nack, 1);
        idle(1, 'h5000);
        check(s_nack == 1 && s_grant == 0, "R6 full table", s_nack, 1);
        idle(0, 'h5000);
        check(s_nack == 0 && s_grant == 0, "R10 ask idle", s_nack + s_grant, 0);

        // out-of-order release of tag 5; its block still conflicts this cycle
        cyc(0, 0, 0, 0, 0, 1, 5, 1, 'h2050);
        check(s_conf == 1, "R11 conflict in response cycle", s_conf, 1);
        idle(1, 'h2057);
        check(s_done == 1 && s_dtag == 5, "R7 retire tag5", s_dtag, 5);
        check(s_conf == 0 && s_tag == 5, "R11 released block free", s_conf, 0);

        // release tag2 while claiming tag5
        cyc(1, 5, 'h6000, 2, 3, 1, 2, 0, 0);
        idle(1, 'h6001);
        check(s_conf == 1 && s_tag == 2, "R8 claim+release both", s_tag, 2);
        // same tag release and reload
        cyc(1, 3, 'h7000, 1, 0, 1, 3, 0, 0);
        idle(1, 'h2030);
        check(s_conf == 0, "R8 old block gone after reload", s_conf, 0);
        check(s_done == 1 && s_dtag == 3, "R8 reload retires old", s_dtag, 3);
        idle(1, 'h7008);
        check(s_conf == 1, "R8 new block held", s_conf, 1);

        // orphan response to free tag 2
        cyc(0, 0, 0, 0, 0, 1, 2, 0, 0);
        idle(1, 'h9990);
        check(s_err == 1 && s_done == 0, "R9 orphan flagged", s_err, 1);
        check(s_tag == 2, "R9 no slot changed", s_tag, 2);

        for (int n = 0; n < 3000; n++) begin
            int  at, dt, pick;
            bit  av, dv;
            dv = ($urandom_range(0, 2) != 0);
            dt = $urandom_range(0, NUM_TAGS - 1);
            av = ($urandom_range(0, 1) == 1);
            pick = -1;
            for (int i = 0; i < NUM_TAGS; i++)
                if (!m_busy[i] && $urandom_range(0, 1) == 1) pick = i;
            if (dv && m_busy[dt] && $urandom_range(0, 3) == 0) pick = dt;
            at = pick;
            if (pick < 0) av = 0;
            cyc(av, (at < 0) ? 0 : at, $urandom_range(0, 'h1FF), $urandom_range(0, 3),
                $urandom_range(0, 3), dv, dt, $urandom_range(0, 1) == 1, $urandom_range(0, 'h1FF));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule